// File: doc/BRIEF.md
# Radix-2 Booth Sequential Signed Multiplier

This block multiplies two signed two's-complement operands of N bits each and produces their 2N-bit signed product, one recoded multiplier bit per clock. A single combined register holds the growing partial product in its upper half and the not-yet-consumed multiplier bits in its lower half. A one-bit history flop to the right of it holds the bit examined in the previous step. The multiplier is recoded on the fly as runs of ones: the block subtracts the multiplicand at the start of a run, adds it back at the end, and only shifts inside a run.

A pulse on `start` while the block is idle captures both operands. N steps follow. Each step may add or subtract the multiplicand on the upper half, then shifts the whole register one place right with sign extension. A one-cycle `done` pulse marks the final result, which stays on `product` until the next accepted start.

Top module: `booth_seq_mult`

## Requirements
- R1: While `rst` is high at a rising edge, `product` becomes zero and `done` becomes low after that edge, even when a multiplication was in progress. No `done` pulse follows a run that a reset abandoned.
- R2: A `start` sampled high while idle captures `mcand` and `mplier`. After that edge, `product` reads `{N zero bits, mplier}`.
- R3: `done` is high for exactly one cycle. It rises after the N-th rising edge that follows the edge that accepted `start`, so it is visible N+1 edges after `start` was sampled.
- R4: When `done` is high, `product` equals the signed product of the captured operands, as a 2N-bit two's-complement value, for every operand pair.
- R5: Operands equal to the most negative N-bit value give correct results in either position, including the square of that value (for N=4, -8 x -8 = 64).
- R6: A `start` sampled while a multiplication is in progress has no effect. The running operation keeps its operands and its completion time.
- R7: Once the block is idle, `product` holds its value until the next accepted `start`.
- R8: Each step examines the pair (bit 0 of `product`, history bit). The history bit is 0 after start. Pair 10 subtracts the multiplicand from the upper half, pair 01 adds it, and pairs 00 and 11 leave the upper half unchanged. The whole register then shifts right by one with the sign kept, and the bit shifted out becomes the new history bit. For N=4 with multiplicand 2 and multiplier 7, `product` reads 8'hF3 after the first step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a multiplication when idle |
| mcand | input | N | Signed multiplicand |
| mplier | input | N | Signed multiplier |
| product | output | 2N | Combined product register; the final signed product when `done` is high |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds one instance with N=4, small enough that all 256 signed operand pairs can be multiplied and compared against the signed product. That includes every run pattern of ones and the most negative operand in both positions. A second instance with N=8 walks a table of vectors that reach 8-bit extremes, mixed signs and alternating bit patterns, where long runs of ones and alternating recoding both occur. Directed cases on the N=4 instance cover the first-step intermediate value, a start while busy, holding after completion, and a reset in the middle of a run.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_ADD  = 2'd1,
        OP_SUB  = 2'd2
    } booth_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic load;
        logic step;
    } ctrl_t;

    // Radix-2 run-of-ones recoding of (current bit, previously examined bit)
    function automatic booth_op_e recode(input logic cur, input logic prev);
        case ({cur, prev})
            2'b10:   return OP_SUB;
            2'b01:   return OP_ADD;
            default: return OP_NONE;
        endcase
    endfunction

endpackage

// File: rtl/booth_ctrl.sv
module booth_ctrl
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output ctrl_t ctl,
    output logic  done
);
    localparam int CW = (N > 2) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;
    logic          busy;

    assign busy     = (state_q == ST_RUN);
    assign ctl.load = (state_q == ST_IDLE) && start;
    assign ctl.step = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                default: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CW'(1);
                    end
                end
            endcase
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R3

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy)); // R3

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
        (busy && start && cnt_q != LAST) |=> (busy && cnt_q == $past(cnt_q) + CW'(1))); // R6

endmodule

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
(
    input  logic      cur_bit,
    input  logic      prev_bit,
    output booth_op_e op
);
    assign op = recode(cur_bit, prev_bit);

    always_comb begin
        if (cur_bit == prev_bit) begin
            AST_RUN_INTERIOR_NOP: assert (op == OP_NONE); // R8
        end
    end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N-1:0] acc,
    input  logic [N-1:0] mcand,
    input  booth_op_e    op,
    output logic [N:0]   res
);
    localparam int EW = N + 1;

    logic [EW-1:0] acc_x;
    logic [EW-1:0] mc_x;

    // One guard bit keeps the true sign even for the most negative multiplicand
    assign acc_x = {acc[N-1], acc};
    assign mc_x  = {mcand[N-1], mcand};

    always_comb begin
        case (op)
            OP_ADD:  res = acc_x + mc_x;
            OP_SUB:  res = acc_x + (~mc_x) + EW'(1);
            default: res = acc_x;
        endcase
    end

    always_comb begin
        if (op == OP_SUB) begin
            AST_SUB_DIFF: assert (res == acc_x - mc_x); // R8
        end
        if (op == OP_ADD) begin
            AST_ADD_SUM: assert ($signed(res) == $signed(acc_x) + $signed(mc_x)); // R8
        end
    end

endmodule

// File: rtl/booth_seq_mult.sv
module booth_seq_mult
    import booth_pkg::*;
#(
    parameter int N = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N-1:0]   mcand,
    input  logic [N-1:0]   mplier,
    output logic [2*N-1:0] product,
    output logic           done
);
    localparam int PW = 2 * N;

    logic [PW-1:0] prod_q;
    logic          prev_q;
    logic [N-1:0]  mcand_q;
    ctrl_t         ctl;
    booth_op_e     op;
    logic [N:0]    upper_res;
    logic [PW-1:0] ref_q;

    booth_ctrl #(.N(N)) u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .ctl   (ctl),
        .done  (done)
    );

    booth_recoder u_recoder (
        .cur_bit  (prod_q[0]),
        .prev_bit (prev_q),
        .op       (op)
    );

    booth_addsub #(.N(N)) u_addsub (
        .acc   (prod_q[PW-1:N]),
        .mcand (mcand_q),
        .op    (op),
        .res   (upper_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q  <= '0;
            prev_q  <= 1'b0;
            mcand_q <= '0;
        end else if (ctl.load) begin
            prod_q  <= {{N{1'b0}}, mplier};
            prev_q  <= 1'b0;
            mcand_q <= mcand;
        end else if (ctl.step) begin
            // Sign-kept right shift of {upper result, lower half}
            prod_q  <= {upper_res, prod_q[N-1:1]};
            prev_q  <= prod_q[0];
        end
    end

    assign product = prod_q;

    // Reference product captured at start, used only by the checks below
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_q <= '0;
        end else if (ctl.load) begin
            ref_q <= $signed({{N{mcand[N-1]}}, mcand}) * $signed({{N{mplier[N-1]}}, mplier});
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (prod_q == '0 && !done)); // R1

    AST_PRODUCT_MATCH: assert property (@(posedge clk) disable iff (rst)
        done |-> (prod_q == ref_q)); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!ctl.step && !ctl.load) |=> $stable(prod_q)); // R7

    AST_LOAD_IMAGE: assert property (@(posedge clk) disable iff (rst)
        ctl.load |=> (prod_q[PW-1:N] == '0 && !prev_q)); // R2

endmodule

// File: tb/booth_seq_mult_test.sv
module booth_seq_mult_test;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 4;
    localparam int NB = 8;

    // {mcand, mplier, expected product}
    localparam logic [31:0] VEC8 [9] = '{
        {8'd2,  8'd7,  16'h000E},
        {8'd2,  8'hFD, 16'hFFFA},
        {8'h80, 8'h80, 16'h4000},
        {8'h80, 8'h01, 16'hFF80},
        {8'h80, 8'hFF, 16'h0080},
        {8'h7F, 8'h7F, 16'h3F01},
        {8'h7F, 8'h80, 16'hC080},
        {8'h55, 8'hAA, 16'hE372},
        {8'h00, 8'h5A, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;

    logic            start4 = 1'b0;
    logic [NA-1:0]   a4 = '0, b4 = '0;
    logic [2*NA-1:0] prod4;
    logic            done4;

    logic            start8 = 1'b0;
    logic [NB-1:0]   a8 = '0, b8 = '0;
    logic [2*NB-1:0] prod8;
    logic            done8;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    booth_seq_mult #(.N(NA)) uut (
        .clk(clk), .rst(rst), .start(start4), .mcand(a4), .mplier(b4),
        .product(prod4), .done(done4)
    );

    booth_seq_mult #(.N(NB)) uut8 (
        .clk(clk), .rst(rst), .start(start8), .mcand(a8), .mplier(b8),
        .product(prod8), .done(done8)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    // Runs one N=4 multiplication; returns at the negedge where done should be high
    task automatic run4(input logic [3:0] a, input logic [3:0] b, input bit timing);
        logic [7:0] exp;
        exp = 8'($signed({{4{a[3]}}, a}) * $signed({{4{b[3]}}, b}));
        @(negedge clk);
        start4 = 1'b1; a4 = a; b4 = b;
        @(negedge clk);
        start4 = 1'b0;
        if (timing) check(prod4 == {4'b0, b}, "R2 load image", 16'(prod4), 16'({4'b0, b}));
        repeat (NA - 1) @(negedge clk);
        if (timing) check(done4 == 1'b0, "R3 done early", 16'(done4), 16'd0);
        @(negedge clk);
        check(done4 == 1'b1, "R3 done", 16'(done4), 16'd1);
        check(prod4 == exp, "R4 product", 16'(prod4), 16'(exp));
        if (timing) begin
            @(negedge clk);
            check(done4 == 1'b0, "R3 one-cycle pulse", 16'(done4), 16'd0);
        end
    endtask

    task automatic run8(input logic [7:0] a, input logic [7:0] b, input logic [15:0] exp);
        @(negedge clk);
        start8 = 1'b1; a8 = a; b8 = b;
        @(negedge clk);
        start8 = 1'b0;
        repeat (NB) @(negedge clk);
        check(done8 == 1'b1, "R3 done n8", 16'(done8), 16'd1);
        check(prod8 == exp, "R4 product n8", prod8, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(prod4 == '0, "R1 reset product", 16'(prod4), 16'd0);
        check(done4 == 1'b0, "R1 reset done", 16'(done4), 16'd0);
        check(prod8 == '0, "R1 reset product n8", prod8, 16'd0);
        rst = 1'b0;

        // R8: first step of 2 x 7 subtracts then shifts -> F3
        @(negedge clk);
        start4 = 1'b1; a4 = 4'd2; b4 = 4'd7;
        @(negedge clk);
        start4 = 1'b0;
        @(negedge clk);
        check(prod4 == 8'hF3, "R8 first step", 16'(prod4), 16'h00F3);
        repeat (NA - 1) @(negedge clk);
        check(prod4 == 8'h0E, "R8 2x7", 16'(prod4), 16'h000E);
        run4(4'd2, 4'hD, 1'b1); // 2 x -3 = FA

        // R5: most negative operand
        run4(4'h8, 4'h8, 1'b1);
        check(prod4 == 8'h40, "R5 -8x-8", 16'(prod4), 16'h0040);
        run4(4'h8, 4'h1, 1'b0);
        check(prod4 == 8'hF8, "R5 -8x1", 16'(prod4), 16'h00F8);
        run4(4'h7, 4'h8, 1'b0);
        check(prod4 == 8'hC8, "R5 7x-8", 16'(prod4), 16'h00C8);

        // R4: exhaustive N=4
        for (int ia = -8; ia < 8; ia++) begin
            for (int ib = -8; ib < 8; ib++) begin
                run4(4'(ia), 4'(ib), 1'b0);
            end
        end

        // R4: table for N=8
        for (int i = 0; i < 9; i++) begin
            run8(VEC8[i][31:24], VEC8[i][23:16], VEC8[i][15:0]);
        end

        // R6: start while busy is ignored
        @(negedge clk);
        start4 = 1'b1; a4 = 4'd3; b4 = 4'd5;
        @(negedge clk);
        start4 = 1'b0;
        @(negedge clk);
        start4 = 1'b1; a4 = 4'd7; b4 = 4'd7;
        @(negedge clk);
        start4 = 1'b0;
        @(negedge clk);
        check(done4 == 1'b0, "R6 no early done", 16'(done4), 16'd0);
        @(negedge clk);
        check(done4 == 1'b1, "R6 done on time", 16'(done4), 16'd1);
        check(prod4 == 8'd15, "R6 original operands", 16'(prod4), 16'd15);

        // R7: product holds while idle, inputs changing
        a4 = 4'd1; b4 = 4'd1;
        repeat (4) @(negedge clk);
        check(prod4 == 8'd15, "R7 hold", 16'(prod4), 16'd15);
        check(done4 == 1'b0, "R7 no done while idle", 16'(done4), 16'd0);

        // R1: reset in the middle of a run
        @(negedge clk);
        start4 = 1'b1; a4 = 4'd5; b4 = 4'd6;
        @(negedge clk);
        start4 = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(prod4 == '0, "R1 mid-run reset product", 16'(prod4), 16'd0);
        check(done4 == 1'b0, "R1 mid-run reset done", 16'(done4), 16'd0);
        rst = 1'b0;
        for (int k = 0; k < NA + 2; k++) begin
            @(negedge clk);
            check(done4 == 1'b0, "R1 no done after abandoned run", 16'(done4), 16'd0);
        end

        summary();
        $finish;
    end

endmodule